// File: doc/BRIEF.md
# Base-Delta-Immediate Cache Line Compressor

The compressor takes one 32-byte cache line per cycle and returns the shortest encoding it can find, along with a 4-bit format code and the encoded length in bytes. Eight candidate encoders look at the same line in parallel:
- one spots a line that is entirely zero;
- one spots a line made of a single 64-bit value repeated;
- six split the line into elements of 8, 4 or 2 bytes and store each element as a narrow signed delta.

In the six delta encoders, the delta is taken against one of two bases. The first choice is the line's first element, used as an explicit base. The fallback is an implicit base of zero. Each element records which base it used in one mask bit. A selector then keeps the valid candidate with the fewest bytes.

The result is registered, so it appears one clock after the line is presented. A line that no encoder can handle is passed through unchanged.

Top module: `bdi_compressor`

## Requirements
- R1: After reset (asynchronous, active-low `rst_n`) all outputs are zero. `out_valid` is high exactly in the cycle after an edge that sampled `in_valid` high. The other outputs reflect that line and hold their value while `in_valid` stays low.
- R2: An all-zero line yields format code 1 (zero), size 1 and an all-zero payload.
- R3: A non-zero line whose four 64-bit words are all equal yields format code 2 (repeated), size 8, the word in payload bits [63:0] and zeros above.
- R4: In a delta format, an element fits when its difference from the base, taken modulo the element width and read as two's complement, lies in the signed range of the delta width. The explicit base (element 0) is tried first. If the element does not fit against it, the element's own value is tried against zero, and that element's mask bit is set to 1. If any element fits neither base, the format is invalid.
- R5: Delta payload layout, little-endian, from bit 0 upward:
  - the base;
  - the deltas in element order;
  - then one mask bit per element, with element i at bit i of the mask field.

  All payload bits above the encoded size are zero.
- R6: Format codes and sizes in bytes (base, delta, mask bytes):

  | Code | Format | Size |
  |---|---|---|
  | 0 | raw | 32 |
  | 1 | zero | 1 |
  | 2 | repeated | 8 |
  | 3 | 8-byte base, 1-byte delta | 13 |
  | 4 | 8-byte base, 2-byte delta | 17 |
  | 5 | 8-byte base, 4-byte delta | 25 |
  | 6 | 4-byte base, 1-byte delta | 13 |
  | 7 | 4-byte base, 2-byte delta | 21 |
  | 8 | 2-byte base, 1-byte delta | 20 |

- R7: Among the valid formats the one with the smallest size is chosen. On equal sizes the lower format code wins; for example, format 3 beats format 6.
- R8: When no format is valid, the output is code 0, size 32, and the payload equals the input line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Line present this cycle |
| in_line | input | 256 | Uncompressed line, byte 0 in bits [7:0] |
| out_valid | output | 1 | Result present |
| out_fmt | output | 4 | Chosen format code |
| out_size | output | 6 | Encoded size in bytes |
| out_payload | output | 256 | Encoded line, zero-padded |

## Verification
The bench aims at the edges of the delta ranges:
- Deltas of exactly +127 and -128 against the explicit base must pass. A design with an off-by-one range test would push such a line to the 17-byte format.
- +128 must fall through to that 17-byte format.

Lines that mix pointers with small negative and positive values check the zero-base fallback and its mask bits. A design that skipped the fallback would emit a raw line, and one that misplaced mask bits would corrupt the payload.

A line that fits both 13-byte formats checks the tie rule; a wrong order would report code 6. Random and low-range random lines check padding and raw passthrough.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    typedef enum logic [3:0] {
        FMT_RAW  = 4'd0,
        FMT_ZERO = 4'd1,
        FMT_REP  = 4'd2,
        FMT_B8D1 = 4'd3,
        FMT_B8D2 = 4'd4,
        FMT_B8D4 = 4'd5,
        FMT_B4D1 = 4'd6,
        FMT_B4D2 = 4'd7,
        FMT_B2D1 = 4'd8
    } fmt_e;

    localparam int NUM_BD   = 6;
    localparam int NUM_CAND = NUM_BD + 2;
    localparam int ZERO_SIZE = 1;
    localparam int REP_BYTES = 8;

    // base width in bytes for delta encoder k (code k+3)
    function automatic int bd_base(input int k);
        case (k)
            0, 1, 2: return 8;
            3, 4:    return 4;
            default: return 2;
        endcase
    endfunction

    // delta width in bytes for delta encoder k
    function automatic int bd_delta(input int k);
        case (k)
            1, 4:    return 2;
            2:       return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/bdi_pattern_unit.sv
module bdi_pattern_unit #(
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 8
) (
    input  logic [LINE_BYTES*8-1:0] line_i,
    output logic                    is_zero_o,
    output logic                    is_rep_o,
    output logic [LINE_BYTES*8-1:0] rep_payload_o
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int NW     = LINE_BYTES / WORD_BYTES;

    logic [NW-1:0] word_eq;

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign word_eq[g] = (line_i[g*WORD_W +: WORD_W] == line_i[WORD_W-1:0]);
    end

    assign is_zero_o     = ~|line_i;
    assign is_rep_o      = &word_eq;
    assign rep_payload_o = {{(LINE_W-WORD_W){1'b0}}, line_i[WORD_W-1:0]};

endmodule

// File: rtl/bdi_bd_unit.sv
module bdi_bd_unit #(
    parameter int LINE_BYTES = 32,
    parameter int BASE_B     = 8,
    parameter int DELTA_B    = 1,
    parameter int SIZE_W     = 6
) (
    input  logic [LINE_BYTES*8-1:0] line_i,
    output logic                    ok_o,
    output logic [SIZE_W-1:0]       size_o,
    output logic [LINE_BYTES*8-1:0] payload_o
);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int N          = LINE_BYTES / BASE_B;
    localparam int EW         = BASE_B * 8;
    localparam int DW         = DELTA_B * 8;
    localparam int MASK_BYTES = (N + 7) / 8;
    localparam int USED_W     = EW + N*DW + N;
    localparam int CSIZE      = BASE_B + N*DELTA_B + MASK_BYTES;

    logic [EW-1:0]         base;
    logic [N-1:0]          el_ok;
    logic [N-1:0]          use_zero;
    logic [N-1:0][DW-1:0]  dlt;

    assign base = line_i[EW-1:0];

    for (genvar g = 0; g < N; g++) begin : g_elem
        logic [EW-1:0] elem;
        logic [EW-1:0] diff;
        logic          fit_base;
        logic          fit_zero;

        assign elem = line_i[g*EW +: EW];
        assign diff = elem - base;

        always_comb begin
            fit_base = (diff == {{(EW-DW){diff[DW-1]}}, diff[DW-1:0]});
            fit_zero = (elem == {{(EW-DW){elem[DW-1]}}, elem[DW-1:0]});
            if (fit_base) begin
                dlt[g]      = diff[DW-1:0];
                use_zero[g] = 1'b0;
                el_ok[g]    = 1'b1;
            end else begin
                dlt[g]      = elem[DW-1:0];
                use_zero[g] = fit_zero;
                el_ok[g]    = fit_zero;
            end
        end
    end

    assign ok_o      = &el_ok;
    assign size_o    = SIZE_W'(CSIZE);
    assign payload_o = {{(LINE_W-USED_W){1'b0}}, use_zero, dlt, base};

endmodule

// File: rtl/bdi_select.sv
module bdi_select #(
    parameter int LINE_W   = 256,
    parameter int SIZE_W   = 6,
    parameter int NUM_CAND = 8
) (
    input  logic [LINE_W-1:0]                 raw_i,
    input  logic [NUM_CAND-1:0]               cand_ok_i,
    input  logic [NUM_CAND-1:0][SIZE_W-1:0]   cand_size_i,
    input  logic [NUM_CAND-1:0][LINE_W-1:0]   cand_pay_i,
    output bdi_pkg::fmt_e                     fmt_o,
    output logic [SIZE_W-1:0]                 size_o,
    output logic [LINE_W-1:0]                 payload_o
);
    localparam int RAW_BYTES = LINE_W / 8;

    always_comb begin
        fmt_o     = bdi_pkg::FMT_RAW;
        size_o    = SIZE_W'(RAW_BYTES);
        payload_o = raw_i;
        // ascending scan with strict compare: lower code wins a tie
        for (int k = 0; k < NUM_CAND; k++) begin
            if (cand_ok_i[k] && (cand_size_i[k] < size_o)) begin
                fmt_o     = bdi_pkg::fmt_e'(4'(k + 1));
                size_o    = cand_size_i[k];
                payload_o = cand_pay_i[k];
            end
        end
    end

endmodule

// File: rtl/bdi_compressor.sv
module bdi_compressor #(
    parameter int LINE_BYTES = 32,
    parameter int SIZE_W     = $clog2(LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LINE_BYTES*8-1:0] in_line,
    output logic                    out_valid,
    output logic [3:0]              out_fmt,
    output logic [SIZE_W-1:0]       out_size,
    output logic [LINE_BYTES*8-1:0] out_payload
);
    import bdi_pkg::*;

    localparam int LINE_W = LINE_BYTES * 8;

    logic                              is_zero, is_rep;
    logic [LINE_W-1:0]                 rep_pay;
    logic [NUM_CAND-1:0]               cand_ok;
    logic [NUM_CAND-1:0][SIZE_W-1:0]   cand_size;
    logic [NUM_CAND-1:0][LINE_W-1:0]   cand_pay;
    fmt_e                              sel_fmt;
    logic [SIZE_W-1:0]                 sel_size;
    logic [LINE_W-1:0]                 sel_pay;

    // next-state values of the output register
    logic                              valid_d;
    logic [3:0]                        fmt_d;
    logic [SIZE_W-1:0]                 size_d;
    logic [LINE_W-1:0]                 pay_d;

    bdi_pattern_unit #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(REP_BYTES)) u_pat (
        .line_i        (in_line),
        .is_zero_o     (is_zero),
        .is_rep_o      (is_rep),
        .rep_payload_o (rep_pay)
    );

    assign cand_ok[0]   = is_zero;
    assign cand_size[0] = SIZE_W'(ZERO_SIZE);
    assign cand_pay[0]  = '0;
    assign cand_ok[1]   = is_rep;
    assign cand_size[1] = SIZE_W'(REP_BYTES);
    assign cand_pay[1]  = rep_pay;

    for (genvar k = 0; k < NUM_BD; k++) begin : g_bd
        bdi_bd_unit #(
            .LINE_BYTES (LINE_BYTES),
            .BASE_B     (bd_base(k)),
            .DELTA_B    (bd_delta(k)),
            .SIZE_W     (SIZE_W)
        ) u_bd (
            .line_i    (in_line),
            .ok_o      (cand_ok[k+2]),
            .size_o    (cand_size[k+2]),
            .payload_o (cand_pay[k+2])
        );
    end

    bdi_select #(.LINE_W(LINE_W), .SIZE_W(SIZE_W), .NUM_CAND(NUM_CAND)) u_sel (
        .raw_i       (in_line),
        .cand_ok_i   (cand_ok),
        .cand_size_i (cand_size),
        .cand_pay_i  (cand_pay),
        .fmt_o       (sel_fmt),
        .size_o      (sel_size),
        .payload_o   (sel_pay)
    );

    always_comb begin
        valid_d = in_valid;
        fmt_d   = out_fmt;
        size_d  = out_size;
        pay_d   = out_payload;
        if (in_valid) begin
            fmt_d  = sel_fmt;
            size_d = sel_size;
            pay_d  = sel_pay;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_fmt     <= 4'd0;
            out_size    <= '0;
            out_payload <= '0;
        end else begin
            out_valid   <= valid_d;
            out_fmt     <= fmt_d;
            out_size    <= size_d;
            out_payload <= pay_d;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_payload))); // R1
    AST_ZERO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_line == '0) |=> (out_fmt == FMT_ZERO && out_size == SIZE_W'(1))); // R2
    AST_PAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt != FMT_RAW) |-> ((out_payload >> {out_size, 3'b000}) == '0)); // R5
    AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size != '0 && out_size <= SIZE_W'(LINE_BYTES) && out_fmt <= 4'd8)); // R6
    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_fmt != FMT_RAW || out_payload == $past(in_line))); // R8

endmodule

// File: tb/bdi_compressor_tb.sv
module bdi_compressor_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] in_line = '0;
    logic         out_valid;
    logic [3:0]   out_fmt;
    logic [5:0]   out_size;
    logic [255:0] out_payload;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bdi_compressor dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_line     (in_line),
        .out_valid   (out_valid),
        .out_fmt     (out_fmt),
        .out_size    (out_size),
        .out_payload (out_payload)
    );

    // ---------------- behavioural reference ----------------
    function automatic longint wrapv(input longint v, input int bb);
        longint r;
        if (bb >= 8) return v;
        r = v & ((longint'(1) << (8*bb)) - 1);
        if (r >= (longint'(1) << (8*bb - 1))) r = r - (longint'(1) << (8*bb));
        return r;
    endfunction

    function automatic longint elem_at(input logic [255:0] ln, input int i, input int bb);
        logic [255:0] t;
        t = ln >> (i*bb*8);
        return wrapv(longint'(t[63:0]), bb);
    endfunction

    // R4 fit rule, R5 layout, R6 size
    function automatic void try_bd(input logic [255:0] ln, input int bb, input int db,
                                   output bit ok, output int sz, output logic [255:0] pl);
        byte unsigned buf_b [32];
        int n, pos, mpos;
        longint b, e, d, lim;
        bit zb;
        for (int j = 0; j < 32; j++) buf_b[j] = 8'h00;
        n    = 32 / bb;
        b    = elem_at(ln, 0, bb);
        lim  = longint'(1) << (8*db - 1);
        mpos = bb + n*db;
        ok   = 1'b1;
        for (int j = 0; j < bb; j++) buf_b[j] = 8'(b >> (8*j));
        pos = bb;
        for (int i = 0; i < n; i++) begin
            e  = elem_at(ln, i, bb);
            d  = wrapv(e - b, bb);
            zb = 1'b0;
            if (!(d >= -lim && d < lim)) begin
                if (e >= -lim && e < lim) begin
                    d  = e;
                    zb = 1'b1;
                end else begin
                    ok = 1'b0;
                end
            end
            for (int j = 0; j < db; j++) buf_b[pos+j] = 8'(d >> (8*j));
            if (zb) buf_b[mpos + i/8] = buf_b[mpos + i/8] | 8'(1 << (i % 8));
            pos = pos + db;
        end
        sz = mpos + (n + 7) / 8;
        for (int j = 0; j < 32; j++) pl[j*8 +: 8] = buf_b[j];
    endfunction

    // R7 choice: smallest, lower code on ties
    function automatic void ref_model(input logic [255:0] ln, output logic [3:0] f,
                                      output int sz, output logic [255:0] pl);
        int bbt [6] = '{8, 8, 8, 4, 4, 2};
        int dbt [6] = '{1, 2, 4, 1, 2, 1};
        bit ok;
        int s;
        logic [255:0] p;
        f = 4'd0; sz = 32; pl = ln;                       // R8
        if (ln == '0) begin f = 4'd1; sz = 1; pl = '0; end // R2
        if (ln[63:0] == ln[127:64] && ln[63:0] == ln[191:128] && ln[63:0] == ln[255:192]
            && 8 < sz) begin                               // R3
            f = 4'd2; sz = 8; pl = {192'd0, ln[63:0]};
        end
        for (int k = 0; k < 6; k++) begin
            try_bd(ln, bbt[k], dbt[k], ok, s, p);
            if (ok && s < sz) begin f = 4'(k + 3); sz = s; pl = p; end
        end
    endfunction

    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'd0:    return "R8";
            4'd1:    return "R2";
            4'd2:    return "R3";
            default: return "R7";
        endcase
    endfunction

    // ---------------- cycle-by-cycle comparison ----------------
    logic         exp_v = 1'b0;
    logic [3:0]   exp_f = '0;
    int           exp_s = 0;
    logic [255:0] exp_p = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 1'b0; exp_f = '0; exp_s = 0; exp_p = '0;   // R1 reset state
        end else if (in_valid) begin
            exp_v = 1'b1;
            ref_model(in_line, exp_f, exp_s, exp_p);
        end else begin
            exp_v = 1'b0;
        end
        #2;
        n_checks++;
        if (out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL R1 valid actual=%0b expected=%0b", out_valid, exp_v);
        end else if (out_fmt !== exp_f) begin
            n_fail++;
            $display("FAIL %s fmt actual=%0d expected=%0d", req_of(exp_f), out_fmt, exp_f);
        end else if (out_size !== 6'(exp_s)) begin
            n_fail++;
            $display("FAIL R6 size actual=%0d expected=%0d", out_size, exp_s);
        end else if (out_payload !== exp_p) begin
            n_fail++;
            $display("FAIL %s payload actual=%h expected=%h",
                     (exp_f > 4'd2) ? "R5" : req_of(exp_f), out_payload, exp_p);
        end
    end

    task automatic send(input logic [255:0] ln);
        @(negedge clk);
        in_valid = 1'b1;
        in_line  = ln;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_line  = {8{32'hA5A5_5A5A}};   // ignored while idle (R1)
        end
    endtask

    initial begin
        logic [255:0] ln;
        logic [63:0]  x;
        logic [31:0]  b32;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        send('0);                                        // R2
        send({4{64'hDEAD_BEEF_1234_5678}});             // R3
        idle(1);
        for (int i = 0; i < 8; i++) ln[i*32 +: 32] = 32'hC040_39C0 + 32'(8*i);
        send(ln);                                        // R6 code 6, 13 bytes
        for (int i = 0; i < 8; i++)
            ln[i*32 +: 32] = (i % 2 == 0) ? 32'hC040_39C0 + 32'(i) : ((i % 4 == 1) ? 32'd5 : 32'hFFFF_FFF0);
        send(ln);                                        // R4 zero-base mask bits
        send({64'd3, 64'd2, 64'd1, 64'd0});              // R7 tie 3 vs 6
        x = 64'h0123_4567_89AB_CD00;
        send({x + 64'd1, x - 64'd128, x + 64'd127, x});  // R4 range edges fit
        send({x + 64'd1, x - 64'd128, x + 64'd128, x});  // R4 +128 needs 2 bytes
        x = 64'h1234_5678_9ABC_0000;
        send({x - 64'd5, 64'hFFFF_FFFF_FFFF_FF00, x + 64'h7000_0000, x}); // R4 R5 code 5
        for (int i = 0; i < 16; i++) ln[i*16 +: 16] = 16'h8000 + 16'(i);
        send(ln);                                        // R6 code 8, 20 bytes
        idle(1);
        send({8{32'hFFFF_FFFF}});                        // R3 all ones
        for (int r = 0; r < 150; r++) begin
            for (int i = 0; i < 8; i++) ln[i*32 +: 32] = $urandom;
            send(ln);                                    // R8 random raw
            b32 = $urandom;
            for (int i = 0; i < 8; i++)
                ln[i*32 +: 32] = (($urandom % 4) == 0) ? 32'($urandom % 200) - 32'd100
                                                      : b32 + 32'($urandom % (1 << (r % 20))) - 32'd300;
            send(ln);                                    // R4 R5 R7 low range
            if (r % 7 == 0) idle(1);
        end
        idle(3);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule